// File: doc/BRIEF.md
# Run-Length Bit Stuffer and Destuffer

This block conditions a serial bit stream so that the line always carries a transition within a bounded number of bit slots. A receiver can then recover the clock from the data. The transmit half accepts one payload bit per cycle through a valid/ready handshake. When the line has carried a run of identical bits of either polarity up to the run limit, the transmit half emits one extra bit of the opposite value. While it does so, it holds off the upstream source.

The receive half watches the incoming line bits and counts runs in the same way. It silently discards the bit that follows a full run, so that only payload reaches its output. If that discarded bit does not break the run as it should, the receive half pulses an error flag. Every inserted bit costs one line slot, so the payload rate is slightly lower than the line rate. Both halves take the run limit from a single shared parameter.

Top module: `rl_line_conditioner`

## Requirements
- R1: After RUN_MAX (default 5) consecutive identical bits on the transmit line, the next line slot carries the inverse of that bit, in the cycle right after the run completes.
- R2: Runs of zeros and runs of ones both trigger insertion, with the same run limit.
- R3: In a cycle in which an inserted bit goes out, tx_in_ready is 0 and no payload bit is consumed. In every other cycle, tx_in_ready is 1.
- R4: An inserted bit counts as the first bit of a new run. For example, ones then an inserted 0 followed by four payload zeros makes a run of five zeros, which forces an inserted 1.
- R5: The transmit line never carries more than RUN_MAX identical bits in a row.
- R6: After the receive line has carried RUN_MAX identical bits, the next valid line bit is dropped: rx_out_valid is 0 in that cycle.
- R7: If the dropped bit equals the run value, rx_stuff_err is 1 for that cycle only. Run tracking then restarts at length one with the dropped bit as its value. rx_stuff_err is 0 on any stream that follows the stuffing rule.
- R8: After reset, tx_in_ready is 1 and tx_line_valid, rx_out_valid and rx_stuff_err are 0 while no input is valid. The first bit after reset starts a run of length one, whatever came before the reset.
- R9: When tx_in_ready and tx_in_valid are both 1, tx_line_bit equals tx_in_bit in the same cycle. A cycle with tx_in_valid at 0 and no insertion pending leaves tx_line_valid at 0 and does not change run tracking.
- R10: When the transmit line is looped back to the receive line, rx_out_bit reproduces every payload bit in order, with nothing missing and nothing extra.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_in_valid | input | 1 | Upstream payload bit is offered |
| tx_in_bit | input | 1 | Upstream payload bit |
| tx_in_ready | output | 1 | Payload bit is consumed this cycle when valid |
| tx_line_valid | output | 1 | A bit occupies the transmit line slot |
| tx_line_bit | output | 1 | Transmit line bit, payload or inserted |
| rx_line_valid | input | 1 | A bit arrives on the receive line |
| rx_line_bit | input | 1 | Receive line bit |
| rx_out_valid | output | 1 | Recovered payload bit is valid |
| rx_out_bit | output | 1 | Recovered payload bit |
| rx_stuff_err | output | 1 | Dropped bit failed to break the run |

## Verification
The checker keeps its own run count of the transmit line and assumes that the line consumes every valid slot, so that no slot can be lost or repeated. It also assumes that the receive line delivers bits in the order they were sent. The stimulus keeps to both assumptions by looping the transmit line straight into the receive line for every payload sweep. The receive half is driven directly only in short, separate sequences that test rule violations, so the error flag is provoked only where the stream deliberately breaks the stuffing rule.

// File: rtl/rl_pkg.sv
package rl_pkg;
  // Default longest run of identical line bits before a forced transition.
  localparam int unsigned RL_RUN_DEFAULT = 5;

  // Counter width able to hold the values 0..run_max.
  function automatic int unsigned rl_cnt_bits(input int unsigned run_max);
    return $clog2(run_max + 1);
  endfunction
endpackage

// File: rtl/rl_run_track.sv
// Tracks the length and polarity of the current run of identical bits.
module rl_run_track #(
  parameter int unsigned RUN_MAX = rl_pkg::RL_RUN_DEFAULT,
  parameter int unsigned CNT_W   = rl_pkg::rl_cnt_bits(RUN_MAX)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,     // a bit occupies the slot this cycle
  input  logic bit_i,
  input  logic restart_i,  // force a new run starting with bit_i
  output logic last_o,
  output logic full_o      // run has reached RUN_MAX
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_MAX);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last_q, last_d;

  always_comb begin
    last_d = bit_i;
    if (restart_i || (cnt_q == '0) || (bit_i != last_q)) begin
      cnt_d = ONE;
    end else if (cnt_q != LIMIT) begin
      cnt_d = cnt_q + ONE;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (step_i) begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  assign last_o = last_q;
  assign full_o = (cnt_q == LIMIT);
endmodule

// File: rtl/rl_stuffer.sv
// Transmit half: forwards payload and inserts an opposite bit after a full run.
module rl_stuffer #(
  parameter int unsigned RUN_MAX = rl_pkg::RL_RUN_DEFAULT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  output logic line_valid,
  output logic line_bit
);
  logic run_last;
  logic run_full;

  always_comb begin
    if (run_full) begin
      in_ready   = 1'b0;
      line_valid = 1'b1;
      line_bit   = ~run_last;
    end else begin
      in_ready   = 1'b1;
      line_valid = in_valid;
      line_bit   = in_bit;
    end
  end

  rl_run_track #(.RUN_MAX(RUN_MAX)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (line_valid),
    .bit_i     (line_bit),
    .restart_i (1'b0),
    .last_o    (run_last),
    .full_o    (run_full)
  );
endmodule

// File: rtl/rl_destuffer.sv
// Receive half: removes the bit that follows a full run and checks its value.
module rl_destuffer #(
  parameter int unsigned RUN_MAX = rl_pkg::RL_RUN_DEFAULT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  output logic out_valid,
  output logic out_bit,
  output logic stuff_err
);
  logic run_last;
  logic run_full;
  logic drop;

  always_comb begin
    drop      = in_valid & run_full;
    out_valid = in_valid & ~run_full;
    out_bit   = in_bit;
    stuff_err = drop & (in_bit == run_last);
  end

  rl_run_track #(.RUN_MAX(RUN_MAX)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (in_valid),
    .bit_i     (in_bit),
    .restart_i (drop),
    .last_o    (run_last),
    .full_o    (run_full)
  );
endmodule

// File: rtl/rl_line_conditioner.sv
module rl_line_conditioner #(
  parameter int unsigned RUN_MAX = rl_pkg::RL_RUN_DEFAULT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_in_valid,
  input  logic tx_in_bit,
  output logic tx_in_ready,
  output logic tx_line_valid,
  output logic tx_line_bit,
  input  logic rx_line_valid,
  input  logic rx_line_bit,
  output logic rx_out_valid,
  output logic rx_out_bit,
  output logic rx_stuff_err
);
  rl_stuffer #(.RUN_MAX(RUN_MAX)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (tx_in_valid),
    .in_bit     (tx_in_bit),
    .in_ready   (tx_in_ready),
    .line_valid (tx_line_valid),
    .line_bit   (tx_line_bit)
  );

  rl_destuffer #(.RUN_MAX(RUN_MAX)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rx_line_valid),
    .in_bit    (rx_line_bit),
    .out_valid (rx_out_valid),
    .out_bit   (rx_out_bit),
    .stuff_err (rx_stuff_err)
  );
endmodule

// File: rtl/rl_line_conditioner_chk.sv
module rl_line_conditioner_chk #(
  parameter int unsigned RUN_MAX = rl_pkg::RL_RUN_DEFAULT
) (
  input logic clk,
  input logic rst_n,
  input logic tx_in_valid,
  input logic tx_in_bit,
  input logic tx_in_ready,
  input logic tx_line_valid,
  input logic tx_line_bit,
  input logic rx_line_valid,
  input logic rx_line_bit,
  input logic rx_out_valid,
  input logic rx_out_bit,
  input logic rx_stuff_err
);
  localparam int unsigned W = $clog2(RUN_MAX + 2);
  localparam logic [W-1:0] LIM = W'(RUN_MAX);

  logic [W-1:0] obs_cnt;
  logic         obs_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obs_cnt  <= '0;
      obs_last <= 1'b0;
    end else if (tx_line_valid) begin
      obs_last <= tx_line_bit;
      if (obs_cnt == '0 || tx_line_bit != obs_last) obs_cnt <= W'(1);
      else if (obs_cnt <= LIM) obs_cnt <= obs_cnt + W'(1);
    end
  end

  // R5
  max_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_line_valid && obs_cnt == LIM) |-> (tx_line_bit != obs_last));

  // R3
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_in_ready |-> tx_line_valid);

  // R9
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_ready && tx_in_valid) |-> (tx_line_valid && tx_line_bit == tx_in_bit));

  // R6
  drop_only_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid |-> (rx_line_valid && rx_out_bit == rx_line_bit));

  // R7
  err_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stuff_err |-> (rx_line_valid && !rx_out_valid));
endmodule

bind rl_line_conditioner rl_line_conditioner_chk #(.RUN_MAX(RUN_MAX)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_in_valid   (tx_in_valid),
  .tx_in_bit     (tx_in_bit),
  .tx_in_ready   (tx_in_ready),
  .tx_line_valid (tx_line_valid),
  .tx_line_bit   (tx_line_bit),
  .rx_line_valid (rx_line_valid),
  .rx_line_bit   (rx_line_bit),
  .rx_out_valid  (rx_out_valid),
  .rx_out_bit    (rx_out_bit),
  .rx_stuff_err  (rx_stuff_err)
);

// File: tb/test_rl_line_conditioner.sv
module test_rl_line_conditioner;
  localparam int RUN = 5;
  localparam int N   = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic tx_in_valid, tx_in_bit, tx_in_ready, tx_line_valid, tx_line_bit;
  logic rx_line_valid, rx_line_bit, rx_out_valid, rx_out_bit, rx_stuff_err;
  logic inj, inj_v, inj_b;

  assign rx_line_valid = inj ? inj_v : tx_line_valid;
  assign rx_line_bit   = inj ? inj_b : tx_line_bit;

  rl_line_conditioner #(.RUN_MAX(RUN)) i_rl_line_conditioner (
    .clk(clk), .rst_n(rst_n),
    .tx_in_valid(tx_in_valid), .tx_in_bit(tx_in_bit), .tx_in_ready(tx_in_ready),
    .tx_line_valid(tx_line_valid), .tx_line_bit(tx_line_bit),
    .rx_line_valid(rx_line_valid), .rx_line_bit(rx_line_bit),
    .rx_out_valid(rx_out_valid), .rx_out_bit(rx_out_bit), .rx_stuff_err(rx_stuff_err)
  );

  int checks = 0;
  int fails  = 0;
  int mcnt, obs_run, rx_idx;
  bit mlast, obs_last;
  bit [N-1:0] pay;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tx_in_valid = 1'b0; tx_in_bit = 1'b0;
    inj = 1'b0; inj_v = 1'b0; inj_b = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mcnt = 0; mlast = 1'b0; obs_run = 0; obs_last = 1'b0; rx_idx = 0;
    #1;
    check(tx_in_ready == 1'b1, "R8 ready after reset", tx_in_ready, 1);
    check(tx_line_valid == 1'b0, "R8 line idle after reset", tx_line_valid, 0);
    check(rx_out_valid == 1'b0 && rx_stuff_err == 1'b0, "R8 rx idle after reset",
          {rx_out_valid, rx_stuff_err}, 0);
  endtask

  // One loopback cycle; took reports whether the payload bit was consumed.
  task automatic cyc(input bit v, input bit b, output bit took);
    bit ev, eb;
    @(negedge clk);
    tx_in_valid = v; tx_in_bit = b;
    #1;
    if (mcnt == RUN) begin
      ev = 1'b1; eb = ~mlast; took = 1'b0;
      check(tx_in_ready == 1'b0, "R3 ready low on insertion", tx_in_ready, 0);
      check(tx_line_valid && tx_line_bit == eb, "R1 R2 R4 inserted bit",
            {tx_line_valid, tx_line_bit}, {1'b1, eb});
      check(rx_out_valid == 1'b0, "R6 inserted bit dropped", rx_out_valid, 0);
    end else begin
      ev = v; eb = b; took = v;
      check(tx_in_ready == 1'b1, "R3 ready high", tx_in_ready, 1);
      check(tx_line_valid == ev, "R9 line valid follows input", tx_line_valid, ev);
      if (v) check(tx_line_bit == b, "R9 payload passthrough", tx_line_bit, b);
    end
    if (tx_line_valid) begin
      if (obs_run != 0 && tx_line_bit == obs_last) obs_run++;
      else obs_run = 1;
      obs_last = tx_line_bit;
      check(obs_run <= RUN, "R5 run bound on line", obs_run, RUN);
    end
    check(rx_stuff_err == 1'b0, "R7 no error on clean stream", rx_stuff_err, 0);
    if (rx_out_valid) begin
      check(rx_idx < N && rx_out_bit == pay[rx_idx % N], "R10 loopback bit",
            rx_out_bit, pay[rx_idx % N]);
      rx_idx++;
    end
    if (ev) begin
      if (mcnt != 0 && eb == mlast) mcnt++;
      else mcnt = 1;
      mlast = eb;
    end
  endtask

  task automatic rx_drive(input bit v, input bit b, input bit exp_out, input bit exp_err,
                          input string tag);
    @(negedge clk);
    inj_v = v; inj_b = b;
    #1;
    check(rx_out_valid == exp_out, tag, rx_out_valid, exp_out);
    check(rx_stuff_err == exp_err, tag, rx_stuff_err, exp_err);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    bit t;
    rst_n = 1'b0;
    // Exhaustive sweep of 10-bit payloads, with an idle gap in every third pattern.
    for (int p = 0; p < (1 << N); p++) begin
      int idx;
      bit gapped;
      do_reset();
      pay = N'(p);
      idx = 0; gapped = 1'b0;
      while (idx < N) begin
        if ((p % 3) == 0 && idx == 4 && !gapped) begin
          cyc(1'b0, 1'b0, t);
          gapped = 1'b1;
        end else begin
          cyc(1'b1, pay[idx], t);
          if (t) idx++;
        end
      end
      cyc(1'b0, 1'b0, t);
      cyc(1'b0, 1'b0, t);
      check(rx_idx == N, "R10 payload count", rx_idx, N);
    end

    // Error sequence on a run of ones, driven straight into the receive half.
    do_reset();
    inj = 1'b1;
    for (int i = 0; i < RUN; i++) rx_drive(1'b1, 1'b1, 1'b1, 1'b0, "R6 run of ones passes");
    rx_drive(1'b1, 1'b1, 1'b0, 1'b0 | 1'b1, "R7 error on equal dropped bit");
    for (int i = 0; i < RUN - 1; i++) rx_drive(1'b1, 1'b1, 1'b1, 1'b0, "R7 single cycle and restart");
    rx_drive(1'b0, 1'b0, 1'b0, 1'b0, "R9 idle slot ignored");
    rx_drive(1'b1, 1'b0, 1'b0, 1'b0, "R7 restart then proper drop");
    rx_drive(1'b1, 1'b0, 1'b1, 1'b0, "R6 payload resumes");

    // Error on a run of zeros.
    do_reset();
    inj = 1'b1;
    for (int i = 0; i < RUN; i++) rx_drive(1'b1, 1'b0, 1'b1, 1'b0, "R2 run of zeros passes");
    rx_drive(1'b1, 1'b0, 1'b0, 1'b1, "R7 error on zero run");
    rx_drive(1'b1, 1'b1, 1'b1, 1'b0, "R7 flag clears");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule